// File: doc/BRIEF.md
# Masked Port Width Splitter

This block presents one masked read/write memory port of width `DATA_W` and builds it from several narrow, unmasked single-port arrays. Each array is exactly one mask segment (`GRAN` bits) wide and has the full logical depth. The block holds `DATA_W/GRAN` of these arrays.

The clock, the address and the access enable go unchanged to every array. Each array receives its own segment of the write word. The read word is the concatenation of the segments that the arrays return. A mask bit does not select bytes inside one wide array. Instead it becomes the write-mode input of the matching narrow array. During a partial write, the arrays whose mask bit is clear run an ordinary read of the same address.

A logical width that is not a whole multiple of the granularity stops elaboration. The arrays are modelled behaviourally, so the storage is not reset. Only the captured read address of each array is reset.

Top module: `mask_split_mem`

## Requirements
- R1: While `rst_n` is low, the captured read address of every slice returns to word 0 and the stored contents are kept. After reset, `rd_data` shows word 0 without any read being issued.
- R2: A write with every `seg_mask` bit set stores the whole `wr_data` word at `acc_addr`. A later read of that address returns the same word. All slices use the shared address.
- R3: The block has `DATA_W/GRAN` slices. Slice i covers bits [GRAN*(i+1)-1 : GRAN*i] of `wr_data` and `rd_data`. Slice i is written only when `acc_en` is 1, `wr_mode` is 1 and `seg_mask[i]` is 1. The other slices of that word keep their old contents.
- R4: While `acc_en` is 0, no slice is written or read, whatever `wr_mode`, `seg_mask`, `acc_addr` and `wr_data` hold.
- R5: A cycle with `acc_en` = 1 and `wr_mode` = 0 reads every slice. The word appears on `rd_data` after the next rising edge, not before it. `rd_data` then holds while `acc_en` stays 0.
- R6: During a write, each slice whose mask bit is 0 reads the addressed word, and its `rd_data` segment shows that word after the edge. Each slice whose mask bit is 1 keeps showing the word it read last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all slices |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_en | input | 1 | Access enable, shared by all slices |
| wr_mode | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | ADDR_W | Word address, shared by all slices |
| seg_mask | input | SLICES | Per-segment write mask; bit i gates slice i |
| wr_data | input | DATA_W | Write word |
| rd_data | output | DATA_W | Read word, concatenated from the slices |

## Verification
The hardest case to reach from the ports is the read data during a partial write. On the same edge, the masked-in segments must show the word read previously, while the masked-out segments must show the word being addressed. To make these two values differ, every masked write is preceded by a read of a different address. The bench then sweeps all sixteen mask values, with a data pattern whose segments are unique per address. Each partial write is followed by a read-back of the merged word.

// File: rtl/mask_split_pkg.sv
`timescale 1ns/1ps
package mask_split_pkg;
  function automatic int seg_count(input int width, input int gran);
    return width / gran;
  endfunction

  function automatic int addr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/ms_rst_sync.sv
`timescale 1ns/1ps
module ms_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ms_slice_ctrl.sv
`timescale 1ns/1ps
module ms_slice_ctrl #(
  parameter int SLICES = 4
) (
  input  logic              acc_en,
  input  logic              wr_mode,
  input  logic [SLICES-1:0] seg_mask,
  output logic [SLICES-1:0] slice_we,
  output logic [SLICES-1:0] slice_re
);
  logic [SLICES-1:0] slice_wmode;

  for (genvar s = 0; s < SLICES; s++) begin : g_gate
    always_comb begin
      slice_wmode[s] = wr_mode & seg_mask[s];
      slice_we[s]    = acc_en & slice_wmode[s];
      slice_re[s]    = acc_en & ~slice_wmode[s];
    end
  end
endmodule

// File: rtl/ms_slice_ram.sv
`timescale 1ns/1ps
module ms_slice_ram #(
  parameter int GRAN   = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [GRAN-1:0]   wdata,
  output logic [GRAN-1:0]   rdata
);
  logic [GRAN-1:0]   store [DEPTH];
  logic [ADDR_W-1:0] raddr_q;
  logic [ADDR_W-1:0] raddr_d;

  always_comb raddr_d = re ? addr : raddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raddr_q <= '0;
    else        raddr_q <= raddr_d;
  end

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[raddr_q];
endmodule

// File: rtl/mask_split_mem.sv
`timescale 1ns/1ps
module mask_split_mem
  import mask_split_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int GRAN   = 8,
  parameter int DEPTH  = 16,
  localparam int SLICES = seg_count(DATA_W, GRAN),
  localparam int ADDR_W = addr_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              wr_mode,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SLICES-1:0] seg_mask,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  if (DATA_W % GRAN != 0) begin : g_bad_gran
    $error("mask_split_mem: DATA_W must be a multiple of GRAN");
  end

  logic              rst_n_int;
  logic [SLICES-1:0] slice_we;
  logic [SLICES-1:0] slice_re;

  ms_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  ms_slice_ctrl #(.SLICES(SLICES)) u_ctrl (
    .acc_en  (acc_en),
    .wr_mode (wr_mode),
    .seg_mask(seg_mask),
    .slice_we(slice_we),
    .slice_re(slice_re)
  );

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    ms_slice_ram #(.GRAN(GRAN), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
      .clk  (clk),
      .rst_n(rst_n_int),
      .we   (slice_we[s]),
      .re   (slice_re[s]),
      .addr (acc_addr),
      .wdata(wr_data[s*GRAN +: GRAN]),
      .rdata(rd_data[s*GRAN +: GRAN])
    );
  end
endmodule

// File: rtl/mask_split_mem_chk.sv
`timescale 1ns/1ps
module mask_split_mem_chk #(
  parameter int DATA_W = 32,
  parameter int SLICES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              wr_mode,
  input logic [SLICES-1:0] seg_mask,
  input logic [DATA_W-1:0] rd_data,
  input logic [SLICES-1:0] slice_we,
  input logic [SLICES-1:0] slice_re
);
  assert_idle_no_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (slice_we == '0 && slice_re == '0));

  assert_mask_gates_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_we & ~seg_mask) == '0);

  assert_write_follows_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && wr_mode) |-> (slice_we == seg_mask));

  assert_unmasked_slices_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && wr_mode) |-> (slice_re == ~seg_mask));

  assert_read_all_slices_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !wr_mode) |-> (slice_re == {SLICES{1'b1}} && slice_we == '0));

  assert_idle_holds_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(rd_data));
endmodule

bind mask_split_mem mask_split_mem_chk #(.DATA_W(DATA_W), .SLICES(SLICES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .acc_en  (acc_en),
  .wr_mode (wr_mode),
  .seg_mask(seg_mask),
  .rd_data (rd_data),
  .slice_we(slice_we),
  .slice_re(slice_re)
);

// File: tb/tb_mask_split_mem.sv
`timescale 1ns/1ps
module tb_mask_split_mem;
  localparam int DW = 32;
  localparam int GR = 8;
  localparam int DP = 16;
  localparam int NS = DW / GR;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_en;
  logic          wr_mode;
  logic [AW-1:0] acc_addr;
  logic [NS-1:0] seg_mask;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] model [DP];

  always #2.5 clk = ~clk;

  mask_split_mem #(.DATA_W(DW), .GRAN(GR), .DEPTH(DP)) dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_mode(wr_mode),
    .acc_addr(acc_addr), .seg_mask(seg_mask), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic e, input logic w, input int a, input logic [NS-1:0] m,
                     input logic [DW-1:0] d);
    acc_en = e; wr_mode = w; acc_addr = AW'(a); seg_mask = m; wr_data = d;
    @(posedge clk); #1;
  endtask

  function automatic logic [DW-1:0] pattern(input int a, input logic inv);
    logic [DW-1:0] p;
    for (int s = 0; s < NS; s++) p[s*GR +: GR] = 8'(a * 16 + s * 3 + 1);
    return inv ? ~p : p;
  endfunction

  initial begin
    rst_n = 1'b0;
    cyc(0, 0, 0, '0, '0);
    repeat (3) cyc(0, 0, 0, '0, '0);
    rst_n = 1'b1;
    repeat (3) cyc(0, 0, 0, '0, '0);

    // R2: full-mask write sweep, then read every word back
    for (int a = 0; a < DP; a++) begin
      model[a] = pattern(a, 1'b0);
      cyc(1, 1, a, '1, model[a]);
    end
    for (int a = 0; a < DP; a++) begin
      cyc(1, 0, a, '0, 32'hDEAD_BEEF);
      check("R2 full write readback", rd_data, model[a]);
    end

    // R5: data not visible before the edge, visible after, held while idle
    cyc(1, 0, 2, '0, '0);
    acc_en = 1'b1; wr_mode = 1'b0; acc_addr = AW'(9);
    @(negedge clk);
    check("R5 no early data", rd_data, model[2]);
    @(posedge clk); #1;
    check("R5 data after edge", rd_data, model[9]);
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, k, '0, '0);
      check("R5 idle hold", rd_data, model[9]);
    end

    // R4: write attempt with enable low changes nothing
    cyc(0, 1, 4, '1, 32'h1234_5678);
    check("R4 idle rd_data untouched", rd_data, model[9]);
    cyc(1, 0, 4, '0, '0);
    check("R4 word kept", rd_data, model[4]);

    // R3 and R6: every mask value, preceded by a read of another word
    for (int m = 0; m < (1 << NS); m++) begin
      int a;
      int b;
      logic [DW-1:0] nd;
      logic [DW-1:0] exp_rd;
      logic [DW-1:0] merged;
      a  = m;
      b  = (m + 5) % DP;
      nd = pattern(a, 1'b1);
      cyc(1, 0, b, '0, '0);
      for (int s = 0; s < NS; s++) begin
        exp_rd[s*GR +: GR] = m[s] ? model[b][s*GR +: GR] : model[a][s*GR +: GR];
        merged[s*GR +: GR] = m[s] ? nd[s*GR +: GR] : model[a][s*GR +: GR];
      end
      cyc(1, 1, a, NS'(m), nd);
      check("R6 read data during masked write", rd_data, exp_rd);
      model[a] = merged;
      cyc(1, 0, a, '0, '0);
      check("R3 merged word after masked write", rd_data, model[a]);
    end

    // R1: reset returns read pointer to word 0, contents kept
    cyc(1, 0, 7, '0, '0);
    check("R1 pre-reset read", rd_data, model[7]);
    rst_n = 1'b0;
    cyc(0, 0, 0, '0, '0);
    check("R1 during reset shows word 0", rd_data, model[0]);
    cyc(0, 0, 0, '0, '0);
    rst_n = 1'b1;
    repeat (3) cyc(0, 0, 0, '0, '0);
    check("R1 after reset shows word 0", rd_data, model[0]);
    cyc(1, 0, 13, '0, '0);
    check("R1 contents survive reset", rd_data, model[13]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule